// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block behaves like a small parallel NOR flash device that is driven by a multi-cycle command protocol on a plain synchronous bus. The bus carries a byte address, write data with a write strobe, and a read strobe with registered read data. Every write is read as a command byte or as data. Which one it is depends on a write-cycle state and on the last command byte that was latched. Every read returns array contents, the 8-bit status register or one entry of a fixed query table, chosen by the latched command.

The storage is a word-wide array of `SECT_NUM` sectors of `SECT_BYTES` bytes each. It is written so that it maps onto one simple dual-port RAM. The supported sequences are single-word program, sector erase with a confirm byte, buffered write with a word count and a confirm byte, lock and unlock, status read, status clear and query. A sector erase writes all-ones over the sector at one word per clock. Status bit 7 stays low until that fill is done. A multi-byte word is made of storage bytes in little-endian lane order. Lane 0 of `wr_data` and `rd_data` is the lowest byte address.

Top module: `nor_cmd_flash`

## Requirements
- R1: After reset, `rd_data` is zero, the device is in array-read mode and the status register is 0x00.
- R2: In the idle state, a command byte (`wr_data[7:0]`) of 0x00 or 0xFF selects array-read mode and clears the latched command. Any unrecognised byte does the same.
- R3: In the idle state, 0x70 latches a status-read command and does not advance the write cycle. 0x50 clears the whole status register to 0x00 and returns to array-read mode.
- R4: 0x10 or 0x40 arms a single-word program. The next write stores its full data word at its word address, sets status bit 7 and returns to idle with array reads.
- R5: 0x20 followed by 0xD0 erases the sector that holds the confirm address. Starting on the clock after the confirm, each of the sector's words is written to all-ones, one per clock. Status bit 7 reads 0 during the fill and is set when the last word is written. Other sectors keep their contents.
- R6: After 0x20, a second byte other than 0xD0 (0xFF or any other value) returns to array-read mode and erases nothing.
- R7: 0xE8 sets status bit 7 and arms a buffered write. The next write gives a count N in its low 8 bits. The N+1 writes after that store data at their addresses. A final 0xD0 returns to idle, and reads still return status.
- R8: In the buffered-write confirm cycle, any byte other than 0xD0 returns to array-read mode. Words already stored are kept.
- R9: 0x60 followed by 0xD0 or 0x01 sets status bit 7 and returns to idle, and reads return status. Any other second byte returns to array-read mode.
- R10: 0x98 enters query mode. A read returns the table entry at index = (byte address bits [7:0]) >> log2(bytes per word), zero-extended. Index 0x10..0x12 hold 0x51, 0x52, 0x59. Index 0x27 holds log2 of the total bytes. Index 0x2D holds the low byte of `SECT_NUM`-1. An index of 0x52 or more reads 0. Writes other than 0xFF stay in query mode, and 0xFF leaves it.
- R11: While the latched command is 0x20, 0x60, 0x70 or 0xE8, reads return the status register. Otherwise they return array data. `rd_data` changes only on the clock edge that samples `rd_en` and holds between reads.
- R12: Writes that arrive during an erase fill are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address for reads and writes |
| wr_en | input | 1 | Write strobe, one write per asserted cycle |
| wr_data | input | DATA_W | Write data; bits [7:0] are the command byte |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Read result, valid the cycle after `rd_en` |

## Verification
A behavioural model in the bench follows the command protocol and predicts `rd_data` on every clock. Single-word programs to two sectors, followed by an erase of one of them, show whether the erase stays inside its sector boundary. Reads taken during the fill show the busy window. Aborted erase, lock and buffered-write sequences are each followed by array reads. These reads separate a return to array mode from a command that is still latched in status mode. Query reads at in-range, empty and out-of-range indices check the index shift for a 16-bit word.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  localparam logic [7:0] OP_NOP      = 8'h00;
  localparam logic [7:0] OP_ARRAY    = 8'hFF;
  localparam logic [7:0] OP_PROG_A   = 8'h10;
  localparam logic [7:0] OP_PROG_B   = 8'h40;
  localparam logic [7:0] OP_ERASE    = 8'h20;
  localparam logic [7:0] OP_CONFIRM  = 8'hD0;
  localparam logic [7:0] OP_CLEAR    = 8'h50;
  localparam logic [7:0] OP_LOCK     = 8'h60;
  localparam logic [7:0] OP_LOCK_ALT = 8'h01;
  localparam logic [7:0] OP_STATUS   = 8'h70;
  localparam logic [7:0] OP_QUERY    = 8'h98;
  localparam logic [7:0] OP_BUFFER   = 8'hE8;

  localparam int QTAB_LEN = 82;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_BUF_DATA,
    ST_BUF_CONF,
    ST_ERASE
  } seq_st_e;

  typedef enum logic [1:0] {
    SRC_ARRAY,
    SRC_STAT,
    SRC_QUERY
  } rd_src_e;
endpackage

// File: rtl/nfc_mem.sv
module nfc_mem #(
  parameter int DATA_W = 16,
  parameter int WORDS  = 128,
  parameter int AW     = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] ram [WORDS];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
  end

  // read-first: a same-edge write is seen by the next read
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= ram[raddr];
  end
endmodule

// File: rtl/nfc_qrom.sv
module nfc_qrom
  import nfc_pkg::*;
#(
  parameter int SECT_BYTES = 64,
  parameter int SECT_NUM   = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       re,
  input  logic [7:0] idx,
  output logic [7:0] q
);
  localparam int          TOTAL    = SECT_BYTES * SECT_NUM;
  localparam logic [7:0]  SIZE_LOG = 8'($clog2(TOTAL));
  localparam logic [15:0] LAST_SEC = 16'(SECT_NUM - 1);
  localparam logic [23:0] SEC_LEN  = 24'(SECT_BYTES);

  logic [7:0] entry;

  always_comb begin
    case (idx)
      8'h10:   entry = 8'h51;
      8'h11:   entry = 8'h52;
      8'h12:   entry = 8'h59;
      8'h13:   entry = 8'h01;
      8'h15:   entry = 8'h31;
      8'h27:   entry = SIZE_LOG;
      8'h28:   entry = 8'h02;
      8'h2A:   entry = 8'h0B;
      8'h2C:   entry = 8'h01;
      8'h2D:   entry = LAST_SEC[7:0];
      8'h2E:   entry = LAST_SEC[15:8];
      8'h2F:   entry = SEC_LEN[15:8];
      8'h30:   entry = SEC_LEN[23:16];
      8'h31:   entry = 8'h50;
      8'h32:   entry = 8'h52;
      8'h33:   entry = 8'h49;
      8'h34:   entry = 8'h31;
      8'h35:   entry = 8'h31;
      default: entry = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (re) q <= (int'(idx) >= QTAB_LEN) ? 8'h00 : entry;
  end
endmodule

// File: rtl/nfc_seq.sv
module nfc_seq
  import nfc_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int WORD_AW    = 7,
  parameter int SECT_WORDS = 32,
  parameter int CNT_W      = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [WORD_AW-1:0] wr_word,
  input  logic [DATA_W-1:0]  wr_data,
  output logic               mem_we,
  output logic [WORD_AW-1:0] mem_waddr,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic [7:0]         status,
  output rd_src_e            rd_src
);
  localparam int FILL_W = $clog2(SECT_WORDS);
  localparam logic [FILL_W-1:0]  FILL_LAST = FILL_W'(SECT_WORDS - 1);
  localparam logic [WORD_AW-1:0] SEC_MASK  = ~WORD_AW'(SECT_WORDS - 1);

  seq_st_e            st_q;
  logic [7:0]         cmd_q;
  logic [7:0]         stat_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FILL_W-1:0]  fill_q;
  logic [WORD_AW-1:0] base_q;
  logic [7:0]         cb;
  logic               prog_cmd;

  assign cb       = wr_data[7:0];
  assign prog_cmd = (cmd_q == OP_PROG_A) || (cmd_q == OP_PROG_B);
  assign status   = stat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      cmd_q  <= OP_NOP;
      stat_q <= '0;
      cnt_q  <= '0;
      fill_q <= '0;
      base_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (wr_en) begin
          case (cb)
            OP_PROG_A, OP_PROG_B, OP_ERASE, OP_LOCK, OP_QUERY: begin
              cmd_q <= cb;
              st_q  <= ST_ARMED;
            end
            OP_BUFFER: begin
              cmd_q     <= cb;
              stat_q[7] <= 1'b1;
              st_q      <= ST_ARMED;
            end
            OP_STATUS: cmd_q <= cb;
            OP_CLEAR: begin
              stat_q <= '0;
              cmd_q  <= OP_NOP;
            end
            default: cmd_q <= OP_NOP;
          endcase
        end
        ST_ARMED: if (wr_en) begin
          if (prog_cmd) begin
            stat_q[7] <= 1'b1;
            st_q      <= ST_IDLE;
          end else if (cmd_q == OP_ERASE && cb == OP_CONFIRM) begin
            stat_q[7] <= 1'b0;
            fill_q    <= '0;
            base_q    <= wr_word & SEC_MASK;
            st_q      <= ST_ERASE;
          end else if (cmd_q == OP_BUFFER) begin
            cnt_q <= wr_data[CNT_W-1:0];
            st_q  <= ST_BUF_DATA;
          end else if (cmd_q == OP_LOCK && (cb == OP_CONFIRM || cb == OP_LOCK_ALT)) begin
            stat_q[7] <= 1'b1;
            st_q      <= ST_IDLE;
          end else if (cmd_q == OP_QUERY && cb != OP_ARRAY) begin
            st_q <= ST_ARMED;
          end else begin
            cmd_q <= OP_NOP;
            st_q  <= ST_IDLE;
          end
        end
        ST_BUF_DATA: if (wr_en) begin
          stat_q[7] <= 1'b1;
          if (cnt_q == '0) st_q <= ST_BUF_CONF;
          else             cnt_q <= cnt_q - 1'b1;
        end
        ST_BUF_CONF: if (wr_en) begin
          st_q <= ST_IDLE;
          if (cb == OP_CONFIRM) stat_q[7] <= 1'b1;
          else                  cmd_q     <= OP_NOP;
        end
        ST_ERASE: begin
          fill_q <= fill_q + 1'b1;
          if (fill_q == FILL_LAST) begin
            stat_q[7] <= 1'b1;
            st_q      <= ST_IDLE;
          end
        end
        default: begin
          cmd_q <= OP_NOP;
          st_q  <= ST_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    mem_we    = 1'b0;
    mem_waddr = wr_word;
    mem_wdata = wr_data;
    if (st_q == ST_ERASE) begin
      mem_we    = 1'b1;
      mem_waddr = base_q | WORD_AW'(fill_q);
      mem_wdata = '1;
    end else if (wr_en && ((st_q == ST_ARMED && prog_cmd) || st_q == ST_BUF_DATA)) begin
      mem_we = 1'b1;
    end
  end

  always_comb begin
    case (cmd_q)
      OP_ERASE, OP_CLEAR, OP_LOCK, OP_STATUS, OP_BUFFER: rd_src = SRC_STAT;
      OP_QUERY: rd_src = SRC_QUERY;
      default:  rd_src = SRC_ARRAY;
    endcase
  end

  assert_erase_busy_R5: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_ERASE) |-> !status[7]);

  assert_erase_end_R5: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_ERASE && fill_q == FILL_LAST) |=> (st_q == ST_IDLE && status[7]));

  assert_buf_confirm_R7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_BUF_DATA && wr_en && cnt_q == '0) |=> (st_q == ST_BUF_CONF));

  assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && wr_en && cb == OP_CLEAR) |=> (status == 8'h00 && rd_src == SRC_ARRAY));

  assert_prog_R4: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_ARMED && wr_en && prog_cmd) |=> (st_q == ST_IDLE && status[7]));
endmodule

// File: rtl/nor_cmd_flash.sv
module nor_cmd_flash
  import nfc_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int SECT_BYTES = 64,
  parameter int SECT_NUM   = 4,
  parameter int CNT_W      = 8,
  parameter int ADDR_W     = $clog2(SECT_BYTES * SECT_NUM)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data
);
  localparam int BYTES      = DATA_W / 8;
  localparam int BYTE_SH    = $clog2(BYTES);
  localparam int WORDS      = (SECT_BYTES * SECT_NUM) / BYTES;
  localparam int WORD_AW    = ADDR_W - BYTE_SH;
  localparam int SECT_WORDS = SECT_BYTES / BYTES;

  logic [WORD_AW-1:0] word_addr;
  logic               mem_we;
  logic [WORD_AW-1:0] mem_waddr;
  logic [DATA_W-1:0]  mem_wdata;
  logic [DATA_W-1:0]  mem_q;
  logic [7:0]         status;
  rd_src_e            rd_src;
  rd_src_e            src_q;
  logic [7:0]         stat_snap;
  logic [7:0]         addr_lo;
  logic [7:0]         qidx;
  logic [7:0]         qbyte;

  assign word_addr = addr[ADDR_W-1:BYTE_SH];

  always_comb begin
    addr_lo = '0;
    for (int i = 0; i < 8 && i < ADDR_W; i++) addr_lo[i] = addr[i];
  end
  assign qidx = addr_lo >> BYTE_SH;

  nfc_seq #(
    .DATA_W(DATA_W), .WORD_AW(WORD_AW), .SECT_WORDS(SECT_WORDS), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_word(word_addr), .wr_data(wr_data),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .status(status), .rd_src(rd_src)
  );

  nfc_mem #(.DATA_W(DATA_W), .WORDS(WORDS), .AW(WORD_AW)) u_mem (
    .clk(clk), .rst(rst), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .re(rd_en), .raddr(word_addr), .rdata(mem_q)
  );

  nfc_qrom #(.SECT_BYTES(SECT_BYTES), .SECT_NUM(SECT_NUM)) u_qrom (
    .clk(clk), .rst(rst), .re(rd_en), .idx(qidx), .q(qbyte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q     <= SRC_ARRAY;
      stat_snap <= '0;
    end else if (rd_en) begin
      src_q     <= rd_src;
      stat_snap <= status;
    end
  end

  always_comb begin
    case (src_q)
      SRC_STAT:  rd_data = DATA_W'(stat_snap);
      SRC_QUERY: rd_data = DATA_W'(qbyte);
      default:   rd_data = mem_q;
    endcase
  end

  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/sim_nor_cmd_flash.sv
`timescale 1ns/1ps
module sim_nor_cmd_flash;
  localparam int DW = 16;
  localparam int SB = 64;
  localparam int SN = 4;
  localparam int AW = 8;
  localparam int SW = SB / 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [DW-1:0] rd_data;

  always #2.5 clk = ~clk;

  nor_cmd_flash #(.DATA_W(DW), .SECT_BYTES(SB), .SECT_NUM(SN)) u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data)
  );

  int    checks = 0;
  int    failures = 0;
  int    cyc = 0;
  string cur_req = "R1";

  // behavioural reference model
  logic [15:0] mem_m [int];
  int          st_m = 0;
  int          cmd_m = 0;
  int          stat_m = 0;
  int          cnt_m = 0;
  int          left_m = 0;
  int          ebase_m = 0;
  logic [15:0] exp_rd = '0;
  bit          exp_ok = 1'b1;

  function automatic int qexp(int idx);
    case (idx)
      'h10: return 'h51;
      'h11: return 'h52;
      'h12: return 'h59;
      'h27: return 8;
      'h2D: return SN - 1;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int w;
    int cb;
    w  = int'(addr) >> 1;
    cb = int'(wr_data[7:0]);
    if (rst) begin
      st_m = 0; cmd_m = 0; stat_m = 0; cnt_m = 0; left_m = 0;
      exp_rd = '0; exp_ok = 1'b1;
    end else begin
      if (rd_en) begin
        if (cmd_m == 'h20 || cmd_m == 'h50 || cmd_m == 'h60 || cmd_m == 'h70 || cmd_m == 'hE8) begin
          exp_rd = 16'(stat_m); exp_ok = 1'b1;
        end else if (cmd_m == 'h98) begin
          exp_rd = 16'(qexp((int'(addr) & 255) >> 1)); exp_ok = 1'b1;
        end else if (mem_m.exists(w)) begin
          exp_rd = mem_m[w]; exp_ok = 1'b1;
        end else exp_ok = 1'b0;
      end
      if (st_m == 4) begin
        mem_m[ebase_m + SW - left_m] = 16'hFFFF;
        left_m--;
        if (left_m == 0) begin st_m = 0; stat_m |= 'h80; end
      end else if (wr_en) begin
        case (st_m)
          0: case (cb)
               'h10, 'h40, 'h20, 'h60, 'h98: begin cmd_m = cb; st_m = 1; end
               'hE8: begin cmd_m = cb; stat_m |= 'h80; st_m = 1; end
               'h70: cmd_m = cb;
               'h50: begin stat_m = 0; cmd_m = 0; end
               default: cmd_m = 0;
             endcase
          1: begin
               if (cmd_m == 'h10 || cmd_m == 'h40) begin
                 mem_m[w] = wr_data; stat_m |= 'h80; st_m = 0;
               end else if (cmd_m == 'h20 && cb == 'hD0) begin
                 st_m = 4; left_m = SW; stat_m &= 'h7F; ebase_m = w & ~(SW - 1);
               end else if (cmd_m == 'hE8) begin
                 cnt_m = cb; st_m = 2;
               end else if (cmd_m == 'h60 && (cb == 'hD0 || cb == 'h01)) begin
                 stat_m |= 'h80; st_m = 0;
               end else if (cmd_m == 'h98 && cb != 'hFF) begin
                 st_m = 1;
               end else begin
                 cmd_m = 0; st_m = 0;
               end
             end
          2: begin
               mem_m[w] = wr_data; stat_m |= 'h80;
               if (cnt_m == 0) st_m = 3; else cnt_m--;
             end
          default: begin
               st_m = 0;
               if (cb == 'hD0) stat_m |= 'h80; else cmd_m = 0;
             end
        endcase
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!rst && exp_ok) begin
      checks++;
      if (rd_data !== exp_rd) begin
        failures++;
        $display("FAIL %s cycle %0d rd_data=%h expected=%h", cur_req, cyc, rd_data, exp_rd);
      end
    end
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = AW'(a); wr_data = DW'(d); wr_en = 1'b1; rd_en = 1'b0;
  endtask

  task automatic rd(input int a);
    @(negedge clk);
    addr = AW'(a); wr_en = 1'b0; rd_en = 1'b1;
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
    end
  endtask

  initial begin
    nop(3);
    @(negedge clk) rst = 1'b0;
    // R1: reset value and a clear status register
    cur_req = "R1";
    nop(2);
    wr(0, 'h70); rd(0); nop(1);

    // R4: both program opcodes
    cur_req = "R4";
    wr('h10, 'h40); wr('h10, 'hA5C3);
    wr('h20, 'h10); wr('h20, 'h1234);
    rd('h10); rd('h20); nop(2);

    // R11: status mode and read-data hold
    cur_req = "R11";
    wr(0, 'h70); rd(0); nop(3); rd('h10); nop(2);

    // R3: clear status then array mode
    cur_req = "R3";
    wr(0, 'h50); rd('h10); wr(0, 'h70); rd(0); nop(1);

    // R2: array-read entry paths
    cur_req = "R2";
    wr(0, 'hFF); rd('h20);
    wr(0, 'h70); wr(0, 'h00); rd('h10);
    wr(0, 'h70); wr(0, 'h33); rd('h20); nop(1);

    // R5: erase sector 1 only, with reads during the fill
    cur_req = "R5";
    wr('h42, 'h40); wr('h42, 'hBEEF);
    wr('h80, 'h40); wr('h80, 'hCAFE);
    wr('h44, 'h20); wr('h44, 'hD0);
    rd(0); rd(0);
    // R12: writes in the fill window are ignored
    cur_req = "R12";
    wr(0, 'h50); wr(0, 'hFF);
    nop(SW + 2);
    rd(0); nop(1);
    cur_req = "R5";
    wr(0, 'hFF);
    rd('h42); rd('h40); rd('h7E); rd('h80); rd('h10); nop(1);

    // R6: aborted erase
    cur_req = "R6";
    wr('h42, 'h40); wr('h42, 'h1111);
    wr('h42, 'h20); wr('h42, 'hFF); rd('h42);
    wr('h42, 'h20); wr('h42, 'h77); rd('h42); nop(1);

    // R7: buffered write of three words
    cur_req = "R7";
    wr(0, 'h50); wr('h90, 'hE8); rd(0);
    wr('h90, 2); wr('h90, 'h0A0A); wr('h92, 'h0B0B); rd(0); wr('h94, 'h0C0C);
    wr('h90, 'hD0); rd(0);
    wr(0, 'hFF); rd('h90); rd('h92); rd('h94); nop(1);

    // R8: bad confirm after a buffered write
    cur_req = "R8";
    wr('h96, 'hE8); wr('h96, 0); wr('h96, 'h5555); wr('h96, 'h12);
    rd('h96); rd('h94); nop(1);

    // R9: lock variants
    cur_req = "R9";
    wr(0, 'h50); wr(0, 'h60); wr(0, 'hD0); rd(0);
    wr(0, 'h50); wr(0, 'h60); wr(0, 'h01); rd(0);
    wr(0, 'h50); wr(0, 'h60); wr(0, 'h33); rd('h90); nop(1);

    // R10: query table reads, stay, leave
    cur_req = "R10";
    wr(0, 'h98);
    rd('h20); rd('h22); rd('h24); rd('h4E); rd('h5A); rd(0); rd('hA6);
    wr(0, 'h12); rd('h22);
    wr(0, 'hFF); rd('h92); nop(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule